// File: doc/BRIEF.md
# Shift-Add Sequential Multiplier

This block multiplies two unsigned operands one bit at a time. A small datapath holds a carry flag, a high accumulator word and a low word. The low word starts out holding the multiplier and ends up holding the low half of the product. A chain of one-hot flip-flops steps through the algorithm. One flip-flop holds the token at a time, and a test on a single bit decides which flip-flop receives it next.

A synchronous reset starts an operation. The operands are presented while reset is applied. The multiplicand must then stay steady until the done flag rises. The multiplier is captured once, in the load step. Each of the `WIDTH` iterations optionally adds the multiplicand into the accumulator, depending on the low bit of the low word. It then shifts carry, accumulator and low word right by one place as a single unit and advances an iteration counter. The run stops when that counter wraps back to zero. The done flag then stays high, and the product stays steady, until the next reset.

Each bit test has an idle step in front of it. That idle step lets the register written by the previous step settle before it is examined. The bit tests are the low-bit test after the load, and the counter test after each shift.

Top module: `shift_add_mul`

## Requirements
- R1: While reset is applied, and in the cycles after it until the run finishes, `ready_o` is low.
- R2: After the second rising edge following reset release, `p_o` equals the multiplier zero-extended (high word zero, low word = `y_i`).
- R3: The add step occurs only in iterations whose examined low bit is 1. `ready_o` therefore first reads high after exactly 3 + 2·`WIDTH` + (number of ones in `y_i`) rising edges after reset release.
- R4: Whenever `ready_o` is high, `p_o` equals the unsigned product `x_i` × `y_i` of the operands present at the start. The high word is in bits [2·WIDTH-1:WIDTH] and the low word is in bits [WIDTH-1:0].
- R5: Once high, `ready_o` stays high and `p_o` stays unchanged until the next reset.
- R6: Changing `y_i` after the load step has no effect on the product or on the finish time.
- R7: Applying reset in the middle of a run abandons it. `ready_o` stays low and a fresh run starts with the new operands.
- R8: A run has exactly `WIDTH` shift iterations and ends when the iteration counter wraps to zero. With `y_i` = 0, `ready_o` is low after edge 2 + 2·`WIDTH` and high after edge 3 + 2·`WIDTH`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset; releasing it starts a run |
| x_i | input | WIDTH | Multiplicand, held steady for the whole run |
| y_i | input | WIDTH | Multiplier, captured in the load step |
| p_o | output | 2*WIDTH | Product (high word, low word); valid while `ready_o` is high |
| ready_o | output | 1 | Registered done flag |

## Verification
The bench builds two copies side by side, with `WIDTH` = 8 and `WIDTH` = 4, and drives them from the same reset. The 4-bit copy is small enough that every one of its 256 operand pairs is run, including each edge case of the counter wrap and the carry out of the add. The 8-bit copy receives the extreme operands (zero, one, all ones, single high bit) plus a pseudo-random spread. It also covers the late multiplier change and the mid-run reset. Both copies are compared every cycle against finish times and products computed from the requirements.

// File: rtl/sam_pkg.sv
`timescale 1ns/1ps
package sam_pkg;
    // Positions of the one-hot sequencer token
    localparam int ST_START = 0;
    localparam int ST_LOAD  = 1;
    localparam int ST_WAITB = 2;
    localparam int ST_ADD   = 3;
    localparam int ST_SHIFT = 4;
    localparam int ST_WAITN = 5;
    localparam int ST_DONE  = 6;
    localparam int NUM_ST   = 7;
endpackage

// File: rtl/sam_datapath.sv
`timescale 1ns/1ps
module sam_datapath #(
    parameter int WIDTH = 8
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               load_i,
    input  logic               add_i,
    input  logic               shift_i,
    input  logic [WIDTH-1:0]   x_i,
    input  logic [WIDTH-1:0]   y_i,
    output logic               lsb_o,
    output logic               cnt_zero_o,
    output logic [2*WIDTH-1:0] prod_o
);
    localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;

    typedef struct packed {
        logic             carry;
        logic [WIDTH-1:0] hi;
        logic [WIDTH-1:0] lo;
        logic [CW-1:0]    cnt;
    } dp_t;

    dp_t dp_d, dp_q;
    logic [WIDTH:0] sum;

    always_comb begin
        dp_d = dp_q;
        sum  = {1'b0, dp_q.hi} + {1'b0, x_i};
        if (load_i) begin
            dp_d.carry = 1'b0;
            dp_d.hi    = '0;
            dp_d.lo    = y_i;
            dp_d.cnt   = '0;
        end else if (add_i) begin
            dp_d.carry = sum[WIDTH];
            dp_d.hi    = sum[WIDTH-1:0];
        end else if (shift_i) begin
            dp_d.carry = 1'b0;
            dp_d.hi    = {dp_q.carry, dp_q.hi[WIDTH-1:1]};
            dp_d.lo    = {dp_q.hi[0], dp_q.lo[WIDTH-1:1]};
            dp_d.cnt   = dp_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign lsb_o      = dp_q.lo[0];
    assign cnt_zero_o = (dp_q.cnt == '0);
    assign prod_o     = {dp_q.hi, dp_q.lo};

    // R2
    load_capture_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> (prod_o == {{WIDTH{1'b0}}, $past(y_i)}));
endmodule

// File: rtl/sam_sequencer.sv
`timescale 1ns/1ps
module sam_sequencer
    import sam_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic lsb_i,
    input  logic cnt_zero_i,
    output logic load_o,
    output logic add_o,
    output logic shift_o,
    output logic done_o
);
    logic [NUM_ST-1:0] tok_d, tok_q;
    logic              steer;

    always_comb begin
        tok_d           = '0;
        steer           = tok_q[ST_WAITB] | (tok_q[ST_WAITN] & ~cnt_zero_i);
        tok_d[ST_LOAD]  = tok_q[ST_START];
        tok_d[ST_WAITB] = tok_q[ST_LOAD];
        tok_d[ST_ADD]   = steer & lsb_i;
        tok_d[ST_SHIFT] = (steer & ~lsb_i) | tok_q[ST_ADD];
        tok_d[ST_WAITN] = tok_q[ST_SHIFT];
        tok_d[ST_DONE]  = tok_q[ST_DONE] | (tok_q[ST_WAITN] & cnt_zero_i);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            tok_q <= NUM_ST'(1) << ST_START;
        end else begin
            tok_q <= tok_d;
        end
    end

    assign load_o  = tok_q[ST_LOAD];
    assign add_o   = tok_q[ST_ADD];
    assign shift_o = tok_q[ST_SHIFT];
    assign done_o  = tok_q[ST_DONE];

    // R8
    single_token_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot(tok_q));

    // R3
    skip_add_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (tok_q[ST_WAITB] && !lsb_i) |=> !add_o);

    // R5
    done_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> done_o);
endmodule

// File: rtl/shift_add_mul.sv
`timescale 1ns/1ps
module shift_add_mul #(
    parameter int WIDTH = 8
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [WIDTH-1:0]   x_i,
    input  logic [WIDTH-1:0]   y_i,
    output logic [2*WIDTH-1:0] p_o,
    output logic               ready_o
);
    logic load, add, shift, lsb, cnt_zero;

    sam_sequencer u_seq (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .lsb_i      (lsb),
        .cnt_zero_i (cnt_zero),
        .load_o     (load),
        .add_o      (add),
        .shift_o    (shift),
        .done_o     (ready_o)
    );

    sam_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .load_i     (load),
        .add_i      (add),
        .shift_i    (shift),
        .x_i        (x_i),
        .y_i        (y_i),
        .lsb_o      (lsb),
        .cnt_zero_o (cnt_zero),
        .prod_o     (p_o)
    );

    // R5
    product_frozen_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(ready_o) && ready_o) |-> $stable(p_o));
endmodule

// File: tb/test_shift_add_mul.sv
`timescale 1ns/1ps
module test_shift_add_mul;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  x8 = '0, y8 = '0;
    logic [3:0]  x4 = '0, y4 = '0;
    logic [15:0] p8;
    logic [7:0]  p4;
    logic        rdy8, rdy4;
    int          checks = 0;
    int          errors = 0;

    always #10 clk = ~clk;

    shift_add_mul #(.WIDTH(8)) i_shift_add_mul (
        .clk_i(clk), .rst_i(rst), .x_i(x8), .y_i(y8), .p_o(p8), .ready_o(rdy8));

    shift_add_mul #(.WIDTH(4)) i_shift_add_mul_w4 (
        .clk_i(clk), .rst_i(rst), .x_i(x4), .y_i(y4), .p_o(p4), .ready_o(rdy4));

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int ones(input int v, input int w);
        int n = 0;
        for (int i = 0; i < w; i++) n += (v >> i) & 1;
        return n;
    endfunction

    // One run of both copies; abort_at > 0 stops after that many edges
    task automatic run_op(input int xa, input int ya, input int xb, input int yb,
                          input bit flip_y, input int abort_at);
        int lat8, lat4, last;
        longint prev8, prev4;
        x8 = 8'(xa); y8 = 8'(ya); x4 = 4'(xb); y4 = 4'(yb);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(rdy8 == 1'b0, "R1 ready8 in reset", rdy8, 0);
        chk(rdy4 == 1'b0, "R1 ready4 in reset", rdy4, 0);
        rst = 1'b0;
        lat8 = 3 + 16 + ones(ya, 8);
        lat4 = 3 + 8 + ones(yb, 4);
        last = (abort_at > 0) ? abort_at : lat8 + 3;
        prev8 = 0; prev4 = 0;
        for (int k = 1; k <= last; k++) begin
            @(posedge clk); @(negedge clk);
            chk(rdy8 == (k >= lat8), "R3 ready8 timing", rdy8, k >= lat8);
            chk(rdy4 == (k >= lat4), "R3 ready4 timing", rdy4, k >= lat4);
            if (ya == 0 && (k == lat8 || k == lat8 - 1))
                chk(rdy8 == (k == lat8), "R8 wrap after 8 shifts", rdy8, k == lat8);
            if (yb == 0 && (k == lat4 || k == lat4 - 1))
                chk(rdy4 == (k == lat4), "R8 wrap after 4 shifts", rdy4, k == lat4);
            if (k == 2) begin
                chk(p8 == 16'(ya), "R2 load8", p8, ya);
                chk(p4 == 8'(yb), "R2 load4", p4, yb);
                if (flip_y) y8 = ~y8;
            end
            if (k >= lat8) begin
                chk(p8 == 16'(xa * ya), flip_y ? "R6 product8 after y change" : "R4 product8",
                    p8, xa * ya);
                if (k > lat8) chk(rdy8 && p8 == prev8, "R5 hold8", p8, prev8);
                prev8 = p8;
            end
            if (k >= lat4) begin
                chk(p4 == 8'(xb * yb), "R4 product4", p4, xb * yb);
                if (k > lat4) chk(rdy4 && p4 == prev4, "R5 hold4", p4, prev4);
                prev4 = p4;
            end
        end
        if (abort_at > 0) begin
            chk(rdy8 == 1'b0, "R7 ready8 low before abort", rdy8, 0);
            chk(rdy4 == 1'b0, "R7 ready4 low before abort", rdy4, 0);
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = 12345;
        // W=8 corners with some W=4 pairs alongside
        run_op(0, 0, 0, 0, 1'b0, 0);
        run_op(255, 255, 15, 15, 1'b0, 0);
        run_op(1, 255, 15, 1, 1'b0, 0);
        run_op(255, 1, 8, 8, 1'b0, 0);
        run_op(128, 128, 0, 15, 1'b0, 0);
        run_op(200, 0, 9, 0, 1'b0, 0);
        // R6: multiplier changes after the load step
        run_op(173, 91, 5, 6, 1'b1, 0);
        run_op(255, 170, 3, 3, 1'b1, 0);
        // R7: reset in the middle, then a fresh run
        run_op(99, 255, 7, 15, 1'b0, 10);
        run_op(37, 200, 11, 13, 1'b0, 0);
        // Exhaustive 4-bit sweep with pseudo-random 8-bit operands
        for (int i = 0; i < 256; i++) begin
            seed = seed * 1103515245 + 12345;
            run_op((seed >> 8) & 255, (seed >> 16) & 255, i >> 4, i & 15, 1'b0, 0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule